// File: doc/BRIEF.md
# USB Host Transaction Launch Gate with Frame-End Babble Halt

This block sits between a USB host transaction scheduler and the bus. Each clock cycle is one bit time. When the scheduler asks to launch a transaction, the gate grants the request only if three things are true. The bus has been quiet for long enough. The transaction, at its stated length in bit times, ends at or before a guard point ahead of the frame boundary. The schedule has not been halted.

The block also watches the last bit time of every frame. If the bus is still busy there, the attached device is taken to have failed. The block then raises a one-cycle babble interrupt and sets a sticky halt flag. While the flag is set, no transaction is granted. Only a software clear input removes the flag.

The frame time comes in from an external frame counter. The frame length, the minimum inter-packet gap and the end-of-frame margin are parameters.

Top module: `usb_txn_gate`

## Requirements
- R1: While reset is held and on the first cycle after it, `start_grant`, `babble_irq` and `halted` are 0, and the idle count starts at zero.
- R2: `start_grant` is 1 only when `bus_active` is 0 in the current cycle and also in each of the preceding `IPG_BITS` cycles (default 2).
- R3: A single cycle with `bus_active` at 1 restarts the idle count from zero, even after a long quiet stretch. The next `IPG_BITS` cycles are then refused.
- R4: `start_grant` requires `frame_time + txn_len <= FRAME_BITS - EOF_MARGIN`. A transaction that would run past that guard point is refused.
- R5: `start_grant` is the combinational AND of `start_req` with the other conditions. Without a request it is 0.
- R6: If `bus_active` is 1 in a cycle where `frame_time == FRAME_BITS-1`, then `babble_irq` is 1 for exactly the following cycle, unless the block is already halted.
- R7: That same babble event sets `halted` from the following cycle. It stays 1 until `sw_clear` is sampled at 1. If a babble event and a clear arrive together, the babble event wins.
- R8: While `halted` is 1, `start_grant` is 0 whatever the other inputs are.
- R9: After `sw_clear` drops the halt, grants resume in the next cycle when the other conditions hold.
- R10: A quiet bus on the last bit time of a frame produces no interrupt and no halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit time per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_active | input | 1 | Bus is carrying traffic in this bit time |
| frame_time | input | CNT_W | Bit time within the current frame, 0 to FRAME_BITS-1 |
| txn_len | input | LEN_W | Duration of the pending transaction in bit times |
| start_req | input | 1 | Scheduler asks to launch the pending transaction |
| sw_clear | input | 1 | Software clear of the halt flag |
| start_grant | output | 1 | Launch permitted in this cycle |
| babble_irq | output | 1 | One-cycle babble interrupt |
| halted | output | 1 | Sticky schedule halt after babble |

## Verification
The launch decision is tried in three ways.

- A table of frame positions and lengths with the bus quiet. Its entries sit just inside, exactly on and one past the guard point. This separates a `<=` comparison from `<` and from an unguarded comparison.
- Bursts of activity followed by counted quiet cycles. These separate a correct gap length from an off-by-one gap. They also catch a counter that fails to restart or ignores activity in the current cycle.
- Activity and silence on the last bit time of a frame, with and without a software clear. These distinguish a pulsed interrupt from a level, a sticky halt from a transient one, and a halt that really blocks grants from one that is only reported.

// File: rtl/usb_txn_gate_pkg.sv
// Package: shared helper for the transaction launch gate.
// Assumes frame times and lengths are unsigned bit-time counts.
package usb_txn_gate_pkg;

    // Width needed to hold values 0..max_val.
    function automatic int width_for(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/txn_idle_timer.sv
// Idle timer: counts quiet bit times since the last bus activity and
// saturates at IPG_BITS. Any activity restarts the count from zero.
// Assumes IPG_BITS >= 1 and one clock per bit time.
module txn_idle_timer #(
    parameter int IPG_BITS = 2,
    localparam int IDLE_W = usb_txn_gate_pkg::width_for(IPG_BITS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_active,
    output logic idle_ok
);
    logic [IDLE_W-1:0] idle_cnt;

    // Restart on activity, otherwise count up to the saturation point.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_active) begin
            idle_cnt <= '0;
        end else if (idle_cnt != IDLE_W'(IPG_BITS)) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // Gap satisfied and the bus is quiet now.
    always_comb begin
        idle_ok = (idle_cnt == IDLE_W'(IPG_BITS)) && !bus_active;
    end
endmodule

// File: rtl/txn_fit_check.sv
// Fit check: decides whether a transaction that starts at the current
// frame time ends at or before the end-of-frame guard point.
// Assumes frame_time and txn_len are unsigned; the sum is widened.
module txn_fit_check #(
    parameter int CNT_W       = 14,
    parameter int LEN_W       = 14,
    parameter int GUARD_POINT = 12000,
    localparam int SUM_W = ((CNT_W > LEN_W) ? CNT_W : LEN_W) + 1
) (
    input  logic [CNT_W-1:0] frame_time,
    input  logic [LEN_W-1:0] txn_len,
    output logic             fits
);
    logic [SUM_W-1:0] end_time;

    // Compute the end bit time and compare it against the guard point.
    always_comb begin
        end_time = SUM_W'(frame_time) + SUM_W'(txn_len);
        fits     = (end_time <= SUM_W'(GUARD_POINT));
    end
endmodule

// File: rtl/txn_babble_mon.sv
// Babble monitor: flags bus activity on the final bit time of a frame.
// It pulses an interrupt once and latches a halt until software clears
// it. A babble event on the same edge as a clear keeps the halt set.
// Assumes frame_last is high for exactly one cycle per frame.
module txn_babble_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_last,
    input  logic bus_active,
    input  logic sw_clear,
    output logic babble_irq,
    output logic halted
);
    logic babble_hit;

    // Detect a new babble event (an already halted schedule stays quiet).
    always_comb begin
        babble_hit = frame_last && bus_active && !halted;
    end

    // One-cycle interrupt and sticky halt with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            babble_irq <= 1'b0;
            halted     <= 1'b0;
        end else begin
            babble_irq <= babble_hit;
            if (babble_hit) begin
                halted <= 1'b1;
            end else if (sw_clear) begin
                halted <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/usb_txn_gate.sv
// Top: USB host transaction launch gate. It grants a start request only
// after the minimum inter-packet gap, only when the transaction fits
// before the guard point, and never while halted after babble.
// Assumes one clock per bit time and an external frame counter.
module usb_txn_gate #(
    parameter int FRAME_BITS = 12000,
    parameter int IPG_BITS   = 2,
    parameter int EOF_MARGIN = 0,
    localparam int CNT_W       = usb_txn_gate_pkg::width_for(FRAME_BITS - 1),
    localparam int LEN_W       = usb_txn_gate_pkg::width_for(FRAME_BITS),
    localparam int GUARD_POINT = FRAME_BITS - EOF_MARGIN,
    localparam int FRAME_LAST  = FRAME_BITS - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_active,
    input  logic [CNT_W-1:0] frame_time,
    input  logic [LEN_W-1:0] txn_len,
    input  logic             start_req,
    input  logic             sw_clear,
    output logic             start_grant,
    output logic             babble_irq,
    output logic             halted
);
    logic idle_ok;
    logic fits;
    logic frame_last;

    txn_idle_timer #(.IPG_BITS(IPG_BITS)) idle_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_active (bus_active),
        .idle_ok    (idle_ok)
    );

    txn_fit_check #(
        .CNT_W       (CNT_W),
        .LEN_W       (LEN_W),
        .GUARD_POINT (GUARD_POINT)
    ) fit_i (
        .frame_time (frame_time),
        .txn_len    (txn_len),
        .fits       (fits)
    );

    txn_babble_mon babble_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_last (frame_last),
        .bus_active (bus_active),
        .sw_clear   (sw_clear),
        .babble_irq (babble_irq),
        .halted     (halted)
    );

    // Combine the final-bit-time decode and the launch decision.
    always_comb begin
        frame_last  = (frame_time == CNT_W'(FRAME_LAST));
        start_grant = start_req && idle_ok && fits && !halted;
    end
endmodule

// File: rtl/usb_txn_gate_chk.sv
// Checker: temporal properties of the launch gate, bound to the top.
// Assumes IPG_BITS >= 1; the quiet-history check looks back one cycle.
module usb_txn_gate_chk #(
    parameter int CNT_W       = 14,
    parameter int LEN_W       = 14,
    parameter int GUARD_POINT = 12000,
    parameter int FRAME_LAST  = 11999
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_active,
    input logic [CNT_W-1:0] frame_time,
    input logic [LEN_W-1:0] txn_len,
    input logic             start_req,
    input logic             sw_clear,
    input logic             start_grant,
    input logic             babble_irq,
    input logic             halted
);
    // R8: a halted schedule never grants.
    a_r8_halt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !start_grant);

    // R4: a grant always fits before the guard point.
    a_r4_fits_frame: assert property (@(posedge clk) disable iff (!rst_n)
        start_grant |-> (int'(frame_time) + int'(txn_len) <= GUARD_POINT));

    // R2: a grant needs a quiet bus now and in the previous cycle.
    a_r2_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        start_grant |-> (!bus_active && !$past(bus_active)));

    // R5: no grant without a request.
    a_r5_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        start_grant |-> start_req);

    // R6: the interrupt lasts a single cycle.
    a_r6_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        babble_irq |=> !babble_irq);

    // R6: the interrupt follows activity on the last bit time.
    a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        babble_irq |-> $past(bus_active && (int'(frame_time) == FRAME_LAST)));

    // R7: the halt holds until a clear is seen.
    a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !sw_clear) |=> halted);
endmodule

bind usb_txn_gate usb_txn_gate_chk #(
    .CNT_W       (CNT_W),
    .LEN_W       (LEN_W),
    .GUARD_POINT (GUARD_POINT),
    .FRAME_LAST  (FRAME_LAST)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_active  (bus_active),
    .frame_time  (frame_time),
    .txn_len     (txn_len),
    .start_req   (start_req),
    .sw_clear    (sw_clear),
    .start_grant (start_grant),
    .babble_irq  (babble_irq),
    .halted      (halted)
);

// File: tb/usb_txn_gate_tb_top.sv
// Bench for the transaction launch gate: frame 100, gap 2, margin 4 (guard 96).
module usb_txn_gate_tb_top;
    localparam int FB  = 100;
    localparam int CW  = 7;
    localparam int LW  = 7;
    localparam int NV  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_active = 1'b0;
    logic [CW-1:0] frame_time = '0;
    logic [LW-1:0] txn_len = '0;
    logic          start_req = 1'b0;
    logic          sw_clear = 1'b0;
    logic          start_grant;
    logic          babble_irq;
    logic          halted;

    int n_cmp = 0;
    int n_bad = 0;

    // Vector table: frame time, length, request, expected grant (R4, R5).
    localparam int VT_FT [NV] = '{10, 90, 90, 95, 96, 0, 40, 10};
    localparam int VT_LN [NV] = '{20,  6,  7,  1,  1, 96, 57, 20};
    localparam int VT_RQ [NV] = '{ 1,  1,  1,  1,  1,  1,  1,  0};
    localparam int VT_GR [NV] = '{ 1,  1,  0,  1,  0,  1,  0,  0};

    always #2.5 clk = ~clk;

    usb_txn_gate #(.FRAME_BITS(FB), .IPG_BITS(2), .EOF_MARGIN(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_active(bus_active),
        .frame_time(frame_time), .txn_len(txn_len), .start_req(start_req),
        .sw_clear(sw_clear), .start_grant(start_grant),
        .babble_irq(babble_irq), .halted(halted)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    // Advance to just after the next rising edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) tick();
        start_req = 1'b1; txn_len = 7'd5; frame_time = 7'd10;
        #1;
        chk("R1 grant in reset", start_grant, 1'b0);
        chk("R1 irq in reset", babble_irq, 1'b0);
        chk("R1 halt in reset", halted, 1'b0);
        rst_n = 1'b1;
        tick();
        #1;
        chk("R1 grant after reset (idle count zero)", start_grant, 1'b0);
        tick(); tick();

        // R4 / R5: table walk with a quiet bus
        for (int i = 0; i < NV; i++) begin
            frame_time = CW'(VT_FT[i]);
            txn_len    = LW'(VT_LN[i]);
            start_req  = VT_RQ[i][0];
            #1;
            chk((VT_RQ[i] == 0) ? "R5 no request" : "R4 frame fit", start_grant, VT_GR[i][0]);
            tick();
        end

        // R2: gap counting after one active cycle
        frame_time = 7'd10; txn_len = 7'd5; start_req = 1'b1;
        bus_active = 1'b1;
        #1;
        chk("R2 busy now", start_grant, 1'b0);
        tick();
        bus_active = 1'b0;
        #1;
        chk("R2 zero quiet cycles", start_grant, 1'b0);
        tick();
        #1;
        chk("R2 one quiet cycle", start_grant, 1'b0);
        tick();
        #1;
        chk("R2 two quiet cycles", start_grant, 1'b1);

        // R3: restart after a long quiet stretch
        repeat (5) tick();
        bus_active = 1'b1;
        tick();
        bus_active = 1'b0;
        #1;
        chk("R3 restart after activity", start_grant, 1'b0);
        tick();
        #1;
        chk("R3 still within gap", start_grant, 1'b0);
        tick();

        // R10: quiet last bit time
        frame_time = 7'd99; txn_len = 7'd1;
        tick();
        frame_time = 7'd0;
        #1;
        chk("R10 no irq on quiet end", babble_irq, 1'b0);
        chk("R10 no halt on quiet end", halted, 1'b0);

        // R6 / R7: babble on the last bit time
        frame_time = 7'd99; bus_active = 1'b1;
        tick();
        frame_time = 7'd0; bus_active = 1'b0;
        #1;
        chk("R6 irq after babble", babble_irq, 1'b1);
        chk("R7 halt after babble", halted, 1'b1);
        tick();
        #1;
        chk("R6 irq single cycle", babble_irq, 1'b0);
        chk("R7 halt sticky", halted, 1'b1);
        repeat (4) tick();
        frame_time = 7'd10; txn_len = 7'd5;
        #1;
        chk("R8 halt blocks grant", start_grant, 1'b0);

        // R6: repeated babble while halted gives no new pulse
        frame_time = 7'd99; bus_active = 1'b1;
        tick();
        bus_active = 1'b0; frame_time = 7'd10;
        #1;
        chk("R6 no pulse while halted", babble_irq, 1'b0);
        repeat (3) tick();

        // R9: software clear releases the halt
        sw_clear = 1'b1;
        tick();
        sw_clear = 1'b0;
        #1;
        chk("R9 halt cleared", halted, 1'b0);
        chk("R9 grant resumes", start_grant, 1'b1);

        // R7: babble and clear on the same edge, the set wins
        frame_time = 7'd99; bus_active = 1'b1; sw_clear = 1'b1;
        tick();
        sw_clear = 1'b0; bus_active = 1'b0; frame_time = 7'd10;
        #1;
        chk("R7 set beats clear", halted, 1'b1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule